// File: doc/BRIEF.md
# Machine Check and Debug Entry Controller

This block sits in a CPU core. It decides how the core reacts to a machine-check event, and it handles exceptions that arrive while the core is already halted in debug mode. Four configuration bits choose the reaction to a machine check: the machine-check-enable status bit, a debug-mode-enable input, and two debug enable bits. The first of these two lets a check-stop-class event go to debug instead. The second lets a machine-check-interrupt-class event go to debug instead. The result is one of three registered, one-hot action pulses: enter check stop, take the machine check interrupt, or enter debug mode.

Once in debug mode, any exception or machine check only rewrites the exception cause register. It also sends a one-cycle error pulse towards the development port. The core stays in debug mode, and no save/restore activity is requested. While in debug mode, instruction fetches are steered to the development port and data cycles go to memory. Check stop is a terminal state that only reset leaves. An explicit return input ends debug mode.

Top module: `mchk_dbg_ctrl`

## Requirements
- R1: With debug mode disabled, a machine check with machine-check-enable 0 yields the check stop action, and with machine-check-enable 1 yields the machine check interrupt action.
- R2: With debug mode enabled, a machine check with machine-check-enable 0 yields debug entry if the check-stop debug bit is 1 and check stop otherwise; with machine-check-enable 1 it yields debug entry if the interrupt debug bit is 1 and the interrupt action otherwise.
- R3: The three action outputs are registered and at most one is high. The chosen action is high for exactly the one cycle after the clock edge that sampled the event, and no action is raised without an event.
- R4: A machine check writes the whole cause register: 0x2000_0000 (bit 29) when machine-check-enable is 0, and 0x1000_0000 (bit 28) when it is 1.
- R5: A check stop action sets the halt output from the same cycle, and only reset clears it. While halted, machine checks and exceptions raise no action, no error pulse, and leave the cause register unchanged.
- R6: A debug entry action sets the in-debug output and the save-registers-first flag in the same cycle. Both stay high until a return-from-debug input is sampled, and both are low from the next cycle.
- R7: In debug mode, an exception with cause index k writes 1<<k into the cause register. A machine check in debug mode writes the value of R4 and takes priority over a simultaneous exception. Neither raises any action output, and the block stays in debug mode.
- R8: The error pulse is high for exactly the one cycle after each sampled exception or machine check in debug mode, and low otherwise. Outside debug mode the exception input is ignored: the cause register is unchanged and no pulse is sent.
- R9: In debug mode a valid fetch cycle is routed to the development port and not to memory. A valid data cycle, or any valid cycle outside debug mode, is routed to memory. Routing is combinational.
- R10: After reset all outputs are low, the cause register is zero and the block is in normal run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mchk_evt | input | 1 | Machine-check event, sampled each edge |
| mchk_en | input | 1 | Machine-check-enable status bit |
| dbg_mode_en | input | 1 | Debug mode enable |
| dbg_on_cstop | input | 1 | Debug enable bit: route check-stop-class events to debug |
| dbg_on_mchk | input | 1 | Debug enable bit: route interrupt-class events to debug |
| exc_evt | input | 1 | Other exception event (acted on only in debug mode) |
| exc_cause | input | CAUSE_W | Bit index of the exception's cause |
| dbg_return | input | 1 | Return from debug mode |
| cyc_valid | input | 1 | A bus cycle is being issued |
| cyc_fetch | input | 1 | The cycle is an instruction fetch (0 = data) |
| act_cstop | output | 1 | Enter check stop action pulse |
| act_mchk_int | output | 1 | Take machine check interrupt action pulse |
| act_dbg | output | 1 | Enter debug mode action pulse |
| halted | output | 1 | Check stop state |
| in_debug | output | 1 | Debug mode active |
| save_regs_flag | output | 1 | Data address/status registers must be saved first |
| ecr | output | ECR_W | Exception cause register |
| ecr_err | output | 1 | One-cycle error pulse to the development port |
| route_dport | output | 1 | Cycle goes to the development port |
| route_mem | output | 1 | Cycle goes to the memory system |

## Verification
The assertions watch several rules on every cycle: the one-hot action pulses, the sticky halt and its silencing of actions, the absence of actions and error pulses in the wrong modes, the error pulse following each debug-mode event, and the routing. They also check the table rows for sampled events. The exact cause register values cannot be shown by the properties, and neither can the ignored-while-halted behaviour or the debug return sequence. The bench covers these by sweeping all sixteen enable combinations and following each resulting mode through exceptions with several cause indices, through machine checks, and through a return.

// File: rtl/mchk_dbg_pkg.sv
// Shared types for the machine check / debug entry controller.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package mchk_dbg_pkg;

    // Outcome chosen for a machine check taken in normal run mode
    typedef enum logic [1:0] {
        ACT_CSTOP = 2'd0,
        ACT_INT   = 2'd1,
        ACT_DBG   = 2'd2
    } mchk_act_e;

    // Operating mode of the core as seen by this block
    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_DBG  = 2'd1,
        MODE_HALT = 2'd2
    } core_mode_e;

endpackage

// File: rtl/mchk_dbg_decide.sv
// Two-level enable table: picks the reaction to a machine check.
// Assumes: inputs are stable when the event is sampled; purely combinational.
module mchk_dbg_decide
    import mchk_dbg_pkg::*;
(
    input  logic      mchk_en,
    input  logic      dbg_mode_en,
    input  logic      dbg_on_cstop,
    input  logic      dbg_on_mchk,
    output mchk_act_e action
);

    // Select the action from the status bit, then the debug enables
    always_comb begin
        if (!mchk_en) begin
            action = (dbg_mode_en && dbg_on_cstop) ? ACT_DBG : ACT_CSTOP;
        end else begin
            action = (dbg_mode_en && dbg_on_mchk) ? ACT_DBG : ACT_INT;
        end
    end

endmodule

// File: rtl/mchk_dbg_mode.sv
// Mode state machine and registered one-hot action pulses.
// Assumes: synchronous active-low reset; check stop is left only by reset,
// debug mode only by an explicit return request.
module mchk_dbg_mode
    import mchk_dbg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mchk_evt,
    input  mchk_act_e  action,
    input  logic       dbg_return,
    output core_mode_e mode,
    output logic       act_cstop,
    output logic       act_mchk_int,
    output logic       act_dbg,
    output logic       save_regs_flag
);

    core_mode_e mode_q;
    logic       take;

    assign take = (mode_q == MODE_RUN) && mchk_evt;
    assign mode = mode_q;

    // Advance the mode on a machine check or a return from debug
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RUN;
        end else begin
            unique case (mode_q)
                MODE_RUN: begin
                    if (take && action == ACT_CSTOP)     mode_q <= MODE_HALT;
                    else if (take && action == ACT_DBG)  mode_q <= MODE_DBG;
                end
                MODE_DBG: begin
                    if (dbg_return) mode_q <= MODE_RUN;
                end
                default: mode_q <= MODE_HALT;
            endcase
        end
    end

    // Register the one-hot action pulses, valid the cycle after sampling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cstop    <= 1'b0;
            act_mchk_int <= 1'b0;
            act_dbg      <= 1'b0;
        end else begin
            act_cstop    <= take && (action == ACT_CSTOP);
            act_mchk_int <= take && (action == ACT_INT);
            act_dbg      <= take && (action == ACT_DBG);
        end
    end

    // Raise the save-first flag on debug entry, drop it on return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            save_regs_flag <= 1'b0;
        end else if (take && action == ACT_DBG) begin
            save_regs_flag <= 1'b1;
        end else if (mode_q == MODE_DBG && dbg_return) begin
            save_regs_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/mchk_dbg_cause.sv
// Exception cause register and the one-cycle error pulse to the debug port.
// Assumes: exceptions other than machine checks matter only in debug mode;
// machine check wins over a simultaneous exception.
module mchk_dbg_cause
    import mchk_dbg_pkg::*;
#(
    parameter int ECR_W     = 32,
    parameter int MCHK_BIT  = 28,
    parameter int CSTOP_BIT = 29,
    localparam int CAUSE_W  = $clog2(ECR_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  core_mode_e         mode,
    input  logic               mchk_evt,
    input  logic               mchk_en,
    input  logic               exc_evt,
    input  logic [CAUSE_W-1:0] exc_cause,
    output logic [ECR_W-1:0]   ecr,
    output logic               ecr_err
);

    localparam logic [ECR_W-1:0] ONE       = {{(ECR_W-1){1'b0}}, 1'b1};
    localparam logic [ECR_W-1:0] MCHK_VAL  = ONE << MCHK_BIT;
    localparam logic [ECR_W-1:0] CSTOP_VAL = ONE << CSTOP_BIT;

    logic live;
    logic dbg;

    assign live = (mode != MODE_HALT);
    assign dbg  = (mode == MODE_DBG);

    // Record the cause of the latest accepted event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecr <= '0;
        end else if (live && mchk_evt) begin
            ecr <= mchk_en ? MCHK_VAL : CSTOP_VAL;
        end else if (dbg && exc_evt) begin
            ecr <= ONE << exc_cause;
        end
    end

    // Pulse the error indication once per event seen in debug mode
    always_ff @(posedge clk) begin
        if (!rst_n) ecr_err <= 1'b0;
        else        ecr_err <= dbg && (mchk_evt || exc_evt);
    end

endmodule

// File: rtl/mchk_dbg_route.sv
// Steers bus cycles: fetches to the development port in debug mode,
// everything else to memory. Assumes combinational routing is acceptable.
module mchk_dbg_route (
    input  logic dbg,
    input  logic cyc_valid,
    input  logic cyc_fetch,
    output logic route_dport,
    output logic route_mem
);

    // Decide the target of the current cycle
    always_comb begin
        route_dport = cyc_valid && cyc_fetch && dbg;
        route_mem   = cyc_valid && !(cyc_fetch && dbg);
    end

endmodule

// File: rtl/mchk_dbg_ctrl.sv
// Top: machine check reaction and debug-mode exception handling.
// Assumes: one event sampled per clock; synchronous active-low reset.
module mchk_dbg_ctrl
    import mchk_dbg_pkg::*;
#(
    parameter int ECR_W     = 32,
    parameter int MCHK_BIT  = 28,
    parameter int CSTOP_BIT = 29,
    localparam int CAUSE_W  = $clog2(ECR_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mchk_evt,
    input  logic               mchk_en,
    input  logic               dbg_mode_en,
    input  logic               dbg_on_cstop,
    input  logic               dbg_on_mchk,
    input  logic               exc_evt,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic               dbg_return,
    input  logic               cyc_valid,
    input  logic               cyc_fetch,
    output logic               act_cstop,
    output logic               act_mchk_int,
    output logic               act_dbg,
    output logic               halted,
    output logic               in_debug,
    output logic               save_regs_flag,
    output logic [ECR_W-1:0]   ecr,
    output logic               ecr_err,
    output logic               route_dport,
    output logic               route_mem
);

    mchk_act_e  action;
    core_mode_e mode;

    mchk_dbg_decide u_decide (
        .mchk_en      (mchk_en),
        .dbg_mode_en  (dbg_mode_en),
        .dbg_on_cstop (dbg_on_cstop),
        .dbg_on_mchk  (dbg_on_mchk),
        .action       (action)
    );

    mchk_dbg_mode u_mode (
        .clk            (clk),
        .rst_n          (rst_n),
        .mchk_evt       (mchk_evt),
        .action         (action),
        .dbg_return     (dbg_return),
        .mode           (mode),
        .act_cstop      (act_cstop),
        .act_mchk_int   (act_mchk_int),
        .act_dbg        (act_dbg),
        .save_regs_flag (save_regs_flag)
    );

    mchk_dbg_cause #(
        .ECR_W     (ECR_W),
        .MCHK_BIT  (MCHK_BIT),
        .CSTOP_BIT (CSTOP_BIT)
    ) u_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .mchk_evt  (mchk_evt),
        .mchk_en   (mchk_en),
        .exc_evt   (exc_evt),
        .exc_cause (exc_cause),
        .ecr       (ecr),
        .ecr_err   (ecr_err)
    );

    mchk_dbg_route u_route (
        .dbg         (in_debug),
        .cyc_valid   (cyc_valid),
        .cyc_fetch   (cyc_fetch),
        .route_dport (route_dport),
        .route_mem   (route_mem)
    );

    assign halted   = (mode == MODE_HALT);
    assign in_debug = (mode == MODE_DBG);

endmodule

// File: rtl/mchk_dbg_chk.sv
// Checker for mchk_dbg_ctrl, attached by bind. Observes ports only.
module mchk_dbg_chk (
    input logic clk,
    input logic rst_n,
    input logic mchk_evt,
    input logic mchk_en,
    input logic dbg_mode_en,
    input logic dbg_on_cstop,
    input logic dbg_on_mchk,
    input logic exc_evt,
    input logic cyc_valid,
    input logic cyc_fetch,
    input logic act_cstop,
    input logic act_mchk_int,
    input logic act_dbg,
    input logic halted,
    input logic in_debug,
    input logic save_regs_flag,
    input logic ecr_err,
    input logic route_dport,
    input logic route_mem
);

    logic run;
    assign run = !halted && !in_debug;

    // R1
    r1_cstop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mchk_evt && !mchk_en && !dbg_mode_en) |=> act_cstop);

    // R2
    r2_dbg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mchk_evt && dbg_mode_en && mchk_en && dbg_on_mchk) |=> act_dbg);

    // R3
    r3_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_cstop, act_mchk_int, act_dbg}));

    // R3
    r3_no_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mchk_evt |=> !(act_cstop || act_mchk_int || act_dbg));

    // R5
    r5_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted && !act_cstop && !act_mchk_int && !act_dbg && !ecr_err);

    // R6
    r6_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_dbg |-> in_debug && save_regs_flag);

    // R7
    r7_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_debug && mchk_evt) |=> in_debug && !act_cstop && !act_mchk_int && !act_dbg);

    // R8
    r8_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_debug && (mchk_evt || exc_evt)) |=> ecr_err);

    // R8
    r8_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_debug |=> !ecr_err);

    // R9
    r9_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_fetch && in_debug) |-> route_dport && !route_mem);

endmodule

bind mchk_dbg_ctrl mchk_dbg_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mchk_evt       (mchk_evt),
    .mchk_en        (mchk_en),
    .dbg_mode_en    (dbg_mode_en),
    .dbg_on_cstop   (dbg_on_cstop),
    .dbg_on_mchk    (dbg_on_mchk),
    .exc_evt        (exc_evt),
    .cyc_valid      (cyc_valid),
    .cyc_fetch      (cyc_fetch),
    .act_cstop      (act_cstop),
    .act_mchk_int   (act_mchk_int),
    .act_dbg        (act_dbg),
    .halted         (halted),
    .in_debug       (in_debug),
    .save_regs_flag (save_regs_flag),
    .ecr_err        (ecr_err),
    .route_dport    (route_dport),
    .route_mem      (route_mem)
);

// File: tb/mchk_dbg_ctrl_tb.sv
// Sweeps all sixteen enable combinations and follows each resulting mode.
module mchk_dbg_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ECR_W      = 32;
    localparam int CAUSE_W    = 5;
    localparam logic [31:0] MCHK_V  = 32'h1000_0000;
    localparam logic [31:0] CSTOP_V = 32'h2000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mchk_evt = 0, mchk_en = 0, dbg_mode_en = 0, dbg_on_cstop = 0, dbg_on_mchk = 0;
    logic exc_evt = 0, dbg_return = 0, cyc_valid = 0, cyc_fetch = 0;
    logic [CAUSE_W-1:0] exc_cause = '0;
    logic act_cstop, act_mchk_int, act_dbg, halted, in_debug, save_regs_flag;
    logic [ECR_W-1:0] ecr;
    logic ecr_err, route_dport, route_mem;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mchk_dbg_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .mchk_evt(mchk_evt), .mchk_en(mchk_en),
        .dbg_mode_en(dbg_mode_en), .dbg_on_cstop(dbg_on_cstop), .dbg_on_mchk(dbg_on_mchk),
        .exc_evt(exc_evt), .exc_cause(exc_cause), .dbg_return(dbg_return),
        .cyc_valid(cyc_valid), .cyc_fetch(cyc_fetch),
        .act_cstop(act_cstop), .act_mchk_int(act_mchk_int), .act_dbg(act_dbg),
        .halted(halted), .in_debug(in_debug), .save_regs_flag(save_regs_flag),
        .ecr(ecr), .ecr_err(ecr_err), .route_dport(route_dport), .route_mem(route_mem)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Inputs change at the falling edge; results are read at the next falling edge
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk_acts(input string req, input logic [2:0] exp);
        chk(req, "actions{cs,int,dbg}", {29'd0, act_cstop, act_mchk_int, act_dbg}, {29'd0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 16; c++) begin
            logic me, den, cse, mcie;
            logic [2:0] exp_act;
            logic [31:0] exp_ecr;
            me = c[3]; den = c[2]; cse = c[1]; mcie = c[0];
            // Expected action, R1/R2: 100 check stop, 010 interrupt, 001 debug
            if (!me) exp_act = (den && cse)  ? 3'b001 : 3'b100;
            else     exp_act = (den && mcie) ? 3'b001 : 3'b010;
            exp_ecr = me ? MCHK_V : CSTOP_V;

            @(negedge clk);
            rst_n = 1'b0; mchk_evt = 0; exc_evt = 0; dbg_return = 0; cyc_valid = 0;
            tick(); tick();
            rst_n = 1'b1;
            // R10 reset state
            chk("R10", "acts", {29'd0, act_cstop, act_mchk_int, act_dbg}, 32'd0);
            chk("R10", "ecr", ecr, 32'd0);
            chk("R10", "halt/dbg/flag/err", {28'd0, halted, in_debug, save_regs_flag, ecr_err}, 32'd0);

            mchk_en = me; dbg_mode_en = den; dbg_on_cstop = cse; dbg_on_mchk = mcie;
            mchk_evt = 1'b1;
            tick();
            mchk_evt = 1'b0;
            chk_acts(me ? "R2/R1 me1" : "R2/R1 me0", exp_act);
            chk("R4", "ecr after mchk", ecr, exp_ecr);
            chk("R5", "halted", {31'd0, halted}, {31'd0, exp_act[2]});
            chk("R6", "in_debug", {31'd0, in_debug}, {31'd0, exp_act[0]});
            chk("R6", "save flag", {31'd0, save_regs_flag}, {31'd0, exp_act[0]});
            tick();
            chk_acts("R3", 3'b000);

            if (exp_act[0]) begin
                // R7/R8: exceptions with several cause indices
                for (int k = 0; k < 32; k += 7) begin
                    exc_evt = 1'b1; exc_cause = k[CAUSE_W-1:0];
                    tick();
                    exc_evt = 1'b0;
                    chk("R7", "ecr exc", ecr, 32'd1 << k);
                    chk("R8", "err pulse", {31'd0, ecr_err}, 32'd1);
                    chk_acts("R7", 3'b000);
                    tick();
                    chk("R8", "err one cycle", {31'd0, ecr_err}, 32'd0);
                end
                // R9 routing in debug
                cyc_valid = 1; cyc_fetch = 1; #1;
                chk("R9", "fetch dbg", {30'd0, route_dport, route_mem}, 32'd2);
                cyc_fetch = 0; #1;
                chk("R9", "data dbg", {30'd0, route_dport, route_mem}, 32'd1);
                cyc_valid = 0;
                // R7: machine check in debug with the other status value, plus exception
                mchk_en = ~me; mchk_evt = 1; exc_evt = 1; exc_cause = 5'd3;
                tick();
                mchk_evt = 0; exc_evt = 0;
                chk("R7", "ecr mchk in dbg", ecr, me ? CSTOP_V : MCHK_V);
                chk_acts("R7", 3'b000);
                chk("R7", "stays dbg", {31'd0, in_debug}, 32'd1);
                chk("R8", "err mchk", {31'd0, ecr_err}, 32'd1);
                // R6 return
                dbg_return = 1;
                tick();
                dbg_return = 0;
                chk("R6", "left dbg", {30'd0, in_debug, save_regs_flag}, 32'd0);
                cyc_valid = 1; cyc_fetch = 1; #1;
                chk("R9", "fetch run", {30'd0, route_dport, route_mem}, 32'd1);
                cyc_valid = 0;
            end else if (exp_act[2]) begin
                // R5: events ignored while halted
                mchk_en = 1; dbg_mode_en = 0; mchk_evt = 1; exc_evt = 1; exc_cause = 5'd9;
                tick();
                mchk_evt = 0; exc_evt = 0;
                chk_acts("R5", 3'b000);
                chk("R5", "ecr kept", ecr, CSTOP_V);
                chk("R5", "still halted", {31'd0, halted}, 32'd1);
                chk("R5", "no err", {31'd0, ecr_err}, 32'd0);
            end else begin
                // R8: exception outside debug ignored
                exc_evt = 1; exc_cause = 5'd4;
                tick();
                exc_evt = 0;
                chk("R8", "ecr kept", ecr, MCHK_V);
                chk("R8", "no err", {31'd0, ecr_err}, 32'd0);
                // R1: a later machine check still acts
                mchk_en = 0; dbg_mode_en = 0; mchk_evt = 1;
                tick();
                mchk_evt = 0;
                chk_acts("R1", 3'b100);
                chk("R4", "ecr cstop", ecr, CSTOP_V);
            end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule